// File: doc/BRIEF.md
# Aging Two-Queue Memory Port Arbiter

This block decides which of five requesters may use a shared memory port. The requesters are a main processor, a signal processor, a local bus bridge, the display-refresh DMA channel and the remaining DMA channels. A fresh request first competes in a low-priority queue. If it waits longer than the time-out programmed for its requester, it is promoted to a high-priority queue. Any promoted request beats every request that has not been promoted. Each queue has its own fixed ranking. The two rankings differ, so the display channel, which ranks last when fresh, ranks first once it has aged.

A grant is one-hot and registered. It stays with its owner until that owner pulses its done input. The arbiter then spends one cycle with no grant and makes its next decision in the cycle after that. Each time-out is an 8-bit register written through a small select/data port. Programming every time-out to zero turns the block into a plain fixed-priority arbiter for any request that has been waiting at least one cycle.

Top module: `mem_port_arbiter`

## Requirements
- R1: While reset is high and after it falls, `gnt` is zero until a request arrives, and every time-out register holds 0.
- R2: `gnt` has at most one bit set. It stays zero while no request is pending, and a new grant only goes to a requester whose `req` bit was high in the deciding cycle.
- R3: A grant is held until the owner's `done` bit is sampled high. At that edge `gnt` returns to zero, and the next grant is decided at the following edge.
- R4: Requester index encoding: 0 main processor, 1 signal processor, 2 local bus, 3 display DMA, 4 other DMA. Among un-promoted requests the ranking is 0, 1, 2, then the shared DMA slot, in which index 3 precedes index 4.
- R5: Among promoted requests the ranking is 3, 1, 2, 4.
- R6: If any request is promoted, the grant goes to a promoted request.
- R7: A requester's wait count is the number of clock edges its request has been high without it holding the grant. The request is promoted when that count is greater than its time-out value.
- R8: With a time-out of 0, a request is promoted one cycle after it is raised. With all time-outs 0, requests pending for at least one cycle are served in the R5 order.
- R9: Index 0 is never promoted, whatever its time-out holds.
- R10: A write with `cfg_we` high loads `cfg_data` into the time-out selected by `cfg_sel` (0 to 4, same encoding as R4). Select values 5 to 7 change nothing.
- R11: A requester's wait count returns to zero when its request drops and when it holds the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 5 | Request per requester, index encoding as in R4 |
| done | input | 5 | Completion pulse per requester |
| cfg_we | input | 1 | Time-out register write enable |
| cfg_sel | input | 3 | Time-out register select |
| cfg_data | input | 8 | Time-out value to write |
| gnt | output | 5 | One-hot registered grant |

## Verification
The bench targets the promotion boundary. A wait count equal to the time-out must still lose in the low ranking, and one cycle more must win. A comparator using greater-or-equal, or a counter that starts one off, would hand the local bus the port a cycle early. It runs pairs of grants in which the second decision happens after every survivor has aged, so that swapping the two rankings, or leaving the main processor promotable, picks the wrong winner. It also checks that a request dropped and re-raised, or one re-raised straight after its own grant, starts its count from zero; a counter that kept its value would promote it falsely. Writes to unused select codes are followed by an arbitration whose result changes if any time-out was overwritten by aliasing.

// File: rtl/mpa_pkg.sv
package mpa_pkg;
  localparam int NREQ = 5;
  localparam int IW   = $clog2(NREQ);

  localparam logic [IW-1:0] RQ_MPU  = 3'd0;
  localparam logic [IW-1:0] RQ_DSP  = 3'd1;
  localparam logic [IW-1:0] RQ_LBUS = 3'd2;
  localparam logic [IW-1:0] RQ_DISP = 3'd3;
  localparam logic [IW-1:0] RQ_DMA  = 3'd4;

  // Element [0] is the highest rank.
  localparam logic [NREQ-1:0][IW-1:0] LO_ORDER =
    {RQ_DMA, RQ_DISP, RQ_LBUS, RQ_DSP, RQ_MPU};
  localparam logic [NREQ-1:0][IW-1:0] HI_ORDER =
    {RQ_MPU, RQ_DMA, RQ_LBUS, RQ_DSP, RQ_DISP};

  // Requesters allowed into the promoted queue.
  localparam logic [NREQ-1:0] HI_CAPABLE = 5'b11110;
endpackage

// File: rtl/mpa_aging.sv
module mpa_aging
  import mpa_pkg::*;
#(
  parameter int TMO_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREQ-1:0] req,
  input  logic [NREQ-1:0] gnt,
  input  logic            cfg_we,
  input  logic [IW-1:0]   cfg_sel,
  input  logic [TMO_W-1:0] cfg_data,
  output logic [NREQ-1:0] promoted
);
  localparam int CW = TMO_W + 1;

  for (genvar i = 0; i < NREQ; i++) begin : g_req
    logic [TMO_W-1:0] tmo_q;
    logic [CW-1:0]    wait_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        tmo_q <= '0;
      end else if (cfg_we && cfg_sel == IW'(i)) begin
        tmo_q <= cfg_data;
      end
    end

    always_ff @(posedge clk) begin
      if (rst || !req[i] || gnt[i]) begin
        wait_q <= '0;
      end else if (wait_q != {CW{1'b1}}) begin
        wait_q <= wait_q + 1'b1;
      end
    end

    if (HI_CAPABLE[i]) begin : g_hi
      assign promoted[i] = req[i] && (wait_q > {1'b0, tmo_q});
    end else begin : g_lo
      assign promoted[i] = 1'b0;
    end
  end
endmodule

// File: rtl/mpa_rank_pick.sv
module mpa_rank_pick
  import mpa_pkg::*;
#(
  parameter logic [NREQ-1:0][IW-1:0] ORDER = LO_ORDER
) (
  input  logic [NREQ-1:0] cand,
  output logic [NREQ-1:0] win
);
  always_comb begin
    win = '0;
    for (int k = NREQ - 1; k >= 0; k--) begin
      if (cand[ORDER[k]]) begin
        win = '0;
        win[ORDER[k]] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mem_port_arbiter.sv
module mem_port_arbiter
  import mpa_pkg::*;
#(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NREQ-1:0]  req,
  input  logic [NREQ-1:0]  done,
  input  logic             cfg_we,
  input  logic [IW-1:0]    cfg_sel,
  input  logic [TMO_W-1:0] cfg_data,
  output logic [NREQ-1:0]  gnt
);
  logic [NREQ-1:0] hi_mask;
  logic [NREQ-1:0] win_hi;
  logic [NREQ-1:0] win_lo;
  logic [NREQ-1:0] next_gnt;

  mpa_aging #(.TMO_W(TMO_W)) u_aging (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .gnt      (gnt),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_data (cfg_data),
    .promoted (hi_mask)
  );

  mpa_rank_pick #(.ORDER(HI_ORDER)) u_pick_hi (
    .cand (hi_mask),
    .win  (win_hi)
  );

  mpa_rank_pick #(.ORDER(LO_ORDER)) u_pick_lo (
    .cand (req & ~hi_mask),
    .win  (win_lo)
  );

  assign next_gnt = (|hi_mask) ? win_hi : win_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt <= '0;
    end else if (|(gnt & done)) begin
      gnt <= '0;
    end else if (gnt == '0) begin
      gnt <= next_gnt;
    end
  end
endmodule

// File: rtl/mpa_checker.sv
module mpa_checker
  import mpa_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [NREQ-1:0] req,
  input logic [NREQ-1:0] done,
  input logic [NREQ-1:0] gnt,
  input logic [NREQ-1:0] hi_mask
);
  // R2
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  // R2
  gnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt == '0 && req == '0) |=> gnt == '0);

  // R2
  gnt_to_requester_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt == '0 && req != '0) |=> (gnt != '0 && (gnt & $past(req)) == gnt));

  // R3
  gnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt != '0 && (gnt & done) == '0) |=> $stable(gnt));

  // R3
  gnt_release_chk: assert property (@(posedge clk) disable iff (rst)
    ((gnt & done) != '0) |=> gnt == '0);

  // R6
  hi_first_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt == '0 && hi_mask != '0) |=> (gnt & $past(hi_mask)) != '0);
endmodule

bind mem_port_arbiter mpa_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .req     (req),
  .done    (done),
  .gnt     (gnt),
  .hi_mask (hi_mask)
);

// File: tb/mem_port_arbiter_tb.sv
module mem_port_arbiter_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] req = '0;
  logic [4:0] done = '0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [7:0] cfg_data = '0;
  logic [4:0] gnt;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mem_port_arbiter u_dut (
    .clk(clk), .rst(rst), .req(req), .done(done),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data), .gnt(gnt)
  );

  // {all time-outs zero, request pattern, first grant, second grant}
  localparam logic [15:0] VEC [10] = '{
    {1'b0, 5'b11111, 5'b00001, 5'b00010},
    {1'b0, 5'b11100, 5'b00100, 5'b01000},
    {1'b0, 5'b10010, 5'b00010, 5'b10000},
    {1'b0, 5'b11000, 5'b01000, 5'b10000},
    {1'b1, 5'b11111, 5'b00001, 5'b01000},
    {1'b1, 5'b10110, 5'b00010, 5'b00100},
    {1'b1, 5'b10101, 5'b00001, 5'b00100},
    {1'b1, 5'b11011, 5'b00001, 5'b01000},
    {1'b1, 5'b11110, 5'b00010, 5'b01000},
    {1'b1, 5'b00011, 5'b00001, 5'b00010}
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [4:0] exp);
    checks++;
    if (gnt !== exp) begin
      errors++;
      $display("FAIL %s: gnt=%b expected %b at %0t", tag, gnt, exp, $time);
    end
  endtask

  task automatic wr_tmo(input logic [2:0] sel, input logic [7:0] val);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = val;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic set_all(input logic [7:0] val);
    for (int i = 0; i < 5; i++) wr_tmo(3'(i), val);
  endtask

  // Two back-to-back decisions: first on fresh requests, second after aging.
  task automatic run_pair(input string tag, input logic [4:0] p,
                          input logic [4:0] e1, input logic [4:0] e2);
    req = p;
    step();
    check(tag, e1);
    done = e1; req = p & ~e1;
    step();
    check("R3 release", 5'b0);
    done = '0;
    step();
    check(tag, e2);
    done = e2; req = '0;
    step();
    done = '0;
    step();
  endtask

  // A blocker holds the port while others wait for hold+1 edges.
  task automatic run_blocked(input string tag, input logic [4:0] blk,
                             input logic [4:0] others, input int hold,
                             input logic [4:0] exp);
    req = blk;
    step();
    check("R3 blocker grant", blk);
    req = blk | others;
    for (int h = 0; h < hold; h++) step();
    check("R3 hold", blk);
    done = blk; req = others;
    step();
    check("R3 release", 5'b0);
    done = '0;
    step();
    check(tag, exp);
    done = exp; req = '0;
    step();
    done = '0;
    step();
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: gnt=%b expected completion", gnt);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R1 in reset", 5'b0);
    step();
    rst = 1'b0;
    step();
    step();
    check("R1 idle after reset", 5'b0);
    // R1: time-outs reset to 0, so the second decision uses R5 order.
    run_pair("R1", 5'b11110, 5'b00010, 5'b01000);

    for (int v = 0; v < 10; v++) begin
      set_all(VEC[v][15] ? 8'd0 : 8'd255);
      run_pair(VEC[v][15] ? "R5 R8" : "R4", VEC[v][14:10], VEC[v][9:5], VEC[v][4:0]);
    end

    // R10: unused select codes must not alias onto real time-outs.
    set_all(8'd255);
    wr_tmo(3'd5, 8'd0);
    wr_tmo(3'd6, 8'd0);
    wr_tmo(3'd7, 8'd0);
    run_pair("R10", 5'b11110, 5'b00010, 5'b00100);

    // R6 R9: aged other-DMA beats the never-promoted main processor.
    set_all(8'd0);
    run_blocked("R6 R9", 5'b00010, 5'b10001, 3, 5'b10000);

    // R7: local bus time-out 3, wait count 3 then 4.
    set_all(8'd255);
    wr_tmo(3'd2, 8'd3);
    run_blocked("R7 count equal", 5'b00001, 5'b00110, 2, 5'b00010);
    run_blocked("R7 count above", 5'b00001, 5'b00110, 3, 5'b00100);

    // R11: drop and re-raise restarts the count.
    req = 5'b00001;
    step();
    check("R3 blocker grant", 5'b00001);
    req = 5'b00111;
    step(); step(); step();
    req = 5'b00011;
    step();
    req = 5'b00110; done = 5'b00001;
    step();
    check("R3 release", 5'b0);
    done = '0;
    step();
    check("R11 drop", 5'b00010);
    done = 5'b00010; req = '0;
    step();
    done = '0;
    step();

    // R11: holding the grant restarts the count.
    req = 5'b00001;
    step();
    check("R3 blocker grant", 5'b00001);
    req = 5'b00111;
    step(); step(); step();
    done = 5'b00001; req = 5'b00110;
    step();
    check("R3 release", 5'b0);
    done = '0;
    step();
    check("R7 promoted", 5'b00100);
    done = 5'b00100;
    step();
    check("R3 release", 5'b0);
    done = '0;
    step();
    check("R11 grant", 5'b00010);
    done = 5'b00010; req = '0;
    step();
    done = '0;
    step();
    check("R2 idle", 5'b0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule